// File: doc/BRIEF.md
# Multi-Standard FSK Transmit Modulator

This block turns a serial bit stream into a stream of signed digital sine samples for two low-speed modem standards. A single phase-accumulating oscillator generates every tone. A one-bit standard select picks the standard. An originate/answer select picks the direction. Between them they choose one of four channels, and each channel has its own mark and space frequency. A change of bit only swaps the phase increment, so the waveform never jumps in phase.

The block also produces a one-cycle strobe at sixteen times the active baud rate, which frames the transmit data. A two-bit pattern field can replace the data input with an alternating, all-mark or all-space test stream. When transmit enable is low, every sample is zero. Samples leave at a fixed rate of `CLK_HZ / SAMPLE_DIV`, each marked by a valid strobe. The defaults give an 11.0592 MHz clock and 9600 samples per second.

Top module: `fsk_tx_mod`

## Requirements
- R1: `clk16_o` pulses high for one cycle every `4*BAUD_DIV` cycles (default 2304, 300 baud) when `v21_sel_i`=1, whatever `orig_i` is. With `v21_sel_i`=0 it pulses every `BAUD_DIV` cycles (576, 1200 baud) when `orig_i`=1 and every `16*BAUD_DIV` cycles (9216, 75 baud) when `orig_i`=0.
- R2: With `v21_sel_i`=1 and `orig_i`=1, a mark (bit 1) is sent at 980 Hz and a space (bit 0) at 1180 Hz.
- R3: With `v21_sel_i`=1 and `orig_i`=0, a mark is sent at 1650 Hz and a space at 1850 Hz.
- R4: With `v21_sel_i`=0 and `orig_i`=1, the 1200-baud main channel is used: a mark is sent at 1300 Hz and a space at 2100 Hz.
- R5: With `v21_sel_i`=0 and `orig_i`=0, the 75-baud back channel is used: a mark is sent at 390 Hz and a space at 450 Hz.
- R6: With `pattern_i`=00, the transmitted bit is `txd_i` as registered on each `clk16_o` pulse (1 = mark, 0 = space), and it changes at no other time.
- R7: With `pattern_i`=01, the transmitted bit alternates between mark and space once every 16 `clk16_o` pulses.
- R8: With `pattern_i`=10 every bit is a mark, and with `pattern_i`=11 every bit is a space. In both cases `txd_i` has no effect on the output.
- R9: A sample taken while `tx_en_i`=0 is exactly zero.
- R10: A bit change alters only the phase increment, never the accumulated phase. The step between consecutive samples therefore never exceeds `2*ceil(f*2^LUT_W/Fs)+4`, where f is the higher tone of the active channel.
- R11: `sample_vld_o` is high for one cycle every `SAMPLE_DIV` cycles. The sample is a two's-complement piecewise-parabolic sine whose magnitude never exceeds `2^(AMP_W-2)`, and it is negative in the upper half of each period.
- R12: While reset is asserted, `sample_o`, `sample_vld_o` and `clk16_o` are all zero.
- R13: Each phase increment is `round(f*2^PHASE_W/Fs)`, so every output frequency is within 0.35% of its nominal value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| txd_i | input | 1 | Serial transmit data, 1 = mark |
| v21_sel_i | input | 1 | 1 = 300-baud standard, 0 = 1200/75 standard |
| orig_i | input | 1 | 1 = originate, 0 = answer |
| pattern_i | input | 2 | Bit source: 00 data, 01 alternate, 10 mark, 11 space |
| tx_en_i | input | 1 | Transmit enable; 0 forces zero samples |
| clk16_o | output | 1 | One-cycle strobe at 16x the active baud rate |
| sample_o | output | AMP_W | Signed sine sample |
| sample_vld_o | output | 1 | Marks the cycle in which a new sample is present |

## Verification
The bench measures each of the eight tones by counting sign changes over a fixed number of samples. A design with swapped mark and space, a channel taken from the wrong direction, or a poorly rounded increment lands outside the narrow window. The test patterns run with `txd_i` held opposite to the forced bit, so a leak from the data input shows up as the wrong tone. The alternating stream is checked by its average crossing rate, which a wrong toggle period would shift toward the pure mark or space count. A long back-channel run with toggling bits watches the largest step between samples: a design that resets or jumps its phase on a bit change would produce a step well beyond the slope bound.

// File: rtl/fsk_tx_pkg.sv
package fsk_tx_pkg;

    typedef enum logic [1:0] {
        PAT_DATA  = 2'b00,
        PAT_ALT   = 2'b01,
        PAT_MARK  = 2'b10,
        PAT_SPACE = 2'b11
    } pat_e;

    typedef enum logic [1:0] {
        CH_V21_ORIG = 2'd0,
        CH_V21_ANS  = 2'd1,
        CH_V23_MAIN = 2'd2,
        CH_V23_BACK = 2'd3
    } chan_e;

    localparam longint unsigned F_V21O_MARK  = 980;
    localparam longint unsigned F_V21O_SPACE = 1180;
    localparam longint unsigned F_V21A_MARK  = 1650;
    localparam longint unsigned F_V21A_SPACE = 1850;
    localparam longint unsigned F_MAIN_MARK  = 1300;
    localparam longint unsigned F_MAIN_SPACE = 2100;
    localparam longint unsigned F_BACK_MARK  = 390;
    localparam longint unsigned F_BACK_SPACE = 450;

    // rounded phase step for a tone of f_hz at sample rate fs_hz
    function automatic longint unsigned phase_inc(input longint unsigned f_hz,
                                                  input longint unsigned fs_hz,
                                                  input int unsigned acc_w);
        return ((f_hz << acc_w) + (fs_hz >> 1)) / fs_hz;
    endfunction

endpackage

// File: rtl/fsk_baud_gen.sv
module fsk_baud_gen
    import fsk_tx_pkg::*;
#(
    parameter int BAUD_DIV = 576
) (
    input  logic  clk,
    input  logic  rst_n,
    input  chan_e chan,
    output logic  clk16,
    output logic  bit_tick
);
    localparam int CNT_W = $clog2(16 * BAUD_DIV + 1);
    localparam logic [CNT_W-1:0] TOP_FAST = CNT_W'(BAUD_DIV - 1);
    localparam logic [CNT_W-1:0] TOP_MID  = CNT_W'(4 * BAUD_DIV - 1);
    localparam logic [CNT_W-1:0] TOP_SLOW = CNT_W'(16 * BAUD_DIV - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [3:0]       sub;
    } st_t;

    st_t              st_q, st_d;
    logic [CNT_W-1:0] top;
    logic             wrap;

    always_comb begin
        case (chan)
            CH_V23_MAIN: top = TOP_FAST;
            CH_V23_BACK: top = TOP_SLOW;
            default:     top = TOP_MID;
        endcase
        wrap = (st_q.cnt >= top);
        st_d = st_q;
        if (wrap) begin
            st_d.cnt = '0;
            st_d.sub = st_q.sub + 4'd1;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign clk16    = wrap;
    assign bit_tick = wrap && (st_q.sub == 4'hF);

    // R1: the 16x strobe is a single-cycle pulse
    p_pulse_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        clk16 |=> !clk16)
        else $error("16x strobe wider than one cycle");

endmodule

// File: rtl/fsk_bit_src.sv
module fsk_bit_src
    import fsk_tx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  pat_e pattern,
    input  logic txd,
    input  logic clk16,
    input  logic bit_tick,
    output logic tx_bit
);
    typedef struct packed {
        logic data;
        logic alt;
    } st_t;

    st_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (clk16)    st_d.data = txd;
        if (bit_tick) st_d.alt  = ~st_q.alt;
        case (pattern)
            PAT_DATA:  tx_bit = st_q.data;
            PAT_ALT:   tx_bit = st_q.alt;
            PAT_MARK:  tx_bit = 1'b1;
            default:   tx_bit = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{data: 1'b1, alt: 1'b1};
        else        st_q <= st_d;
    end

    p_data_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk16 && pattern == PAT_DATA) |=> (pattern != PAT_DATA) || $stable(tx_bit))
        else $error("data bit moved between strobes");

    p_alt_flip_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_tick && pattern == PAT_ALT) |=> (pattern != PAT_ALT) || (tx_bit != $past(tx_bit)))
        else $error("alternating bit did not flip at bit boundary");

    p_alt_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_tick && pattern == PAT_ALT) |=> (pattern != PAT_ALT) || $stable(tx_bit))
        else $error("alternating bit flipped inside a bit");

endmodule

// File: rtl/fsk_nco.sv
module fsk_nco
    import fsk_tx_pkg::*;
#(
    parameter int CLK_HZ     = 11059200,
    parameter int SAMPLE_DIV = 1152,
    parameter int PHASE_W    = 24,
    parameter int AMP_W      = 12,
    parameter int LUT_W      = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  chan_e                   chan,
    input  logic                    tx_bit,
    input  logic                    tx_en,
    output logic signed [AMP_W-1:0] sample,
    output logic                    sample_vld
);
    localparam longint unsigned FS = longint'(CLK_HZ) / longint'(SAMPLE_DIV);
    localparam int SC_W   = $clog2(SAMPLE_DIV + 1);
    localparam int HALF_W = LUT_W - 1;
    localparam int PROD_W = 2 * HALF_W;
    localparam int SHIFT  = PROD_W - AMP_W;
    localparam int PEAK   = 1 << (AMP_W - 2);

    localparam logic [PHASE_W-1:0] INC_V21O_M = PHASE_W'(phase_inc(F_V21O_MARK,  FS, PHASE_W));
    localparam logic [PHASE_W-1:0] INC_V21O_S = PHASE_W'(phase_inc(F_V21O_SPACE, FS, PHASE_W));
    localparam logic [PHASE_W-1:0] INC_V21A_M = PHASE_W'(phase_inc(F_V21A_MARK,  FS, PHASE_W));
    localparam logic [PHASE_W-1:0] INC_V21A_S = PHASE_W'(phase_inc(F_V21A_SPACE, FS, PHASE_W));
    localparam logic [PHASE_W-1:0] INC_MAIN_M = PHASE_W'(phase_inc(F_MAIN_MARK,  FS, PHASE_W));
    localparam logic [PHASE_W-1:0] INC_MAIN_S = PHASE_W'(phase_inc(F_MAIN_SPACE, FS, PHASE_W));
    localparam logic [PHASE_W-1:0] INC_BACK_M = PHASE_W'(phase_inc(F_BACK_MARK,  FS, PHASE_W));
    localparam logic [PHASE_W-1:0] INC_BACK_S = PHASE_W'(phase_inc(F_BACK_SPACE, FS, PHASE_W));

    typedef struct packed {
        logic [SC_W-1:0]    scnt;
        logic [PHASE_W-1:0] phase;
        logic [AMP_W-1:0]   smp;
        logic               vld;
    } st_t;

    st_t                st_q, st_d;
    logic [PHASE_W-1:0] inc;
    logic [PHASE_W-1:0] phase_n;

    // two mirrored parabolas approximate one sine period
    function automatic logic [AMP_W-1:0] shape(input logic [PHASE_W-1:0] ph);
        logic [LUT_W-1:0]  idx;
        logic [HALF_W-1:0] x;
        logic [HALF_W:0]   rest;
        logic [AMP_W-1:0]  mag;
        idx  = ph[PHASE_W-1 -: LUT_W];
        x    = idx[HALF_W-1:0];
        rest = (HALF_W + 1)'(1 << HALF_W) - {1'b0, x};
        mag  = AMP_W'((PROD_W'(x) * PROD_W'(rest)) >> SHIFT);
        return idx[LUT_W-1] ? (AMP_W'(0) - mag) : mag;
    endfunction

    always_comb begin
        case ({chan, tx_bit})
            {CH_V21_ORIG, 1'b1}: inc = INC_V21O_M;
            {CH_V21_ORIG, 1'b0}: inc = INC_V21O_S;
            {CH_V21_ANS,  1'b1}: inc = INC_V21A_M;
            {CH_V21_ANS,  1'b0}: inc = INC_V21A_S;
            {CH_V23_MAIN, 1'b1}: inc = INC_MAIN_M;
            {CH_V23_MAIN, 1'b0}: inc = INC_MAIN_S;
            {CH_V23_BACK, 1'b1}: inc = INC_BACK_M;
            default:             inc = INC_BACK_S;
        endcase
        phase_n = st_q.phase + inc;
        st_d     = st_q;
        st_d.vld = 1'b0;
        if (st_q.scnt == SC_W'(SAMPLE_DIV - 1)) begin
            st_d.scnt  = '0;
            st_d.phase = phase_n;
            st_d.smp   = tx_en ? shape(phase_n) : '0;
            st_d.vld   = 1'b1;
        end else begin
            st_d.scnt = st_q.scnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sample     = st_q.smp;
    assign sample_vld = st_q.vld;

    p_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!tx_en) && sample_vld) |-> (sample == '0))
        else $error("sample not zero while disabled");

    p_vld_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        sample_vld |=> !sample_vld)
        else $error("valid strobe wider than one cycle");

    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_vld |-> $stable(sample))
        else $error("sample changed without a strobe");

    p_peak_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(sample) <= PEAK) && (int'(sample) >= -PEAK))
        else $error("sample magnitude above bound");

endmodule

// File: rtl/fsk_tx_mod.sv
module fsk_tx_mod
    import fsk_tx_pkg::*;
#(
    parameter int CLK_HZ     = 11059200,
    parameter int BAUD_DIV   = 576,
    parameter int SAMPLE_DIV = 1152,
    parameter int PHASE_W    = 24,
    parameter int AMP_W      = 12,
    parameter int LUT_W      = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    txd_i,
    input  logic                    v21_sel_i,
    input  logic                    orig_i,
    input  logic [1:0]              pattern_i,
    input  logic                    tx_en_i,
    output logic                    clk16_o,
    output logic signed [AMP_W-1:0] sample_o,
    output logic                    sample_vld_o
);
    chan_e chan;
    pat_e  pat;
    logic  bit_tick;
    logic  tx_bit;

    always_comb begin
        if (v21_sel_i) chan = orig_i ? CH_V21_ORIG : CH_V21_ANS;
        else           chan = orig_i ? CH_V23_MAIN : CH_V23_BACK;
        pat = pat_e'(pattern_i);
    end

    fsk_baud_gen #(
        .BAUD_DIV (BAUD_DIV)
    ) u_baud (
        .clk      (clk),
        .rst_n    (rst_n),
        .chan     (chan),
        .clk16    (clk16_o),
        .bit_tick (bit_tick)
    );

    fsk_bit_src u_bits (
        .clk      (clk),
        .rst_n    (rst_n),
        .pattern  (pat),
        .txd      (txd_i),
        .clk16    (clk16_o),
        .bit_tick (bit_tick),
        .tx_bit   (tx_bit)
    );

    fsk_nco #(
        .CLK_HZ     (CLK_HZ),
        .SAMPLE_DIV (SAMPLE_DIV),
        .PHASE_W    (PHASE_W),
        .AMP_W      (AMP_W),
        .LUT_W      (LUT_W)
    ) u_nco (
        .clk        (clk),
        .rst_n      (rst_n),
        .chan       (chan),
        .tx_bit     (tx_bit),
        .tx_en      (tx_en_i),
        .sample     (sample_o),
        .sample_vld (sample_vld_o)
    );

endmodule

// File: tb/sim_fsk_tx_mod.sv
module sim_fsk_tx_mod;
    localparam int CLK_HZ     = 115200;
    localparam int BAUD_DIV   = 6;
    localparam int SAMPLE_DIV = 12;
    localparam int PHASE_W    = 24;
    localparam int AMP_W      = 12;
    localparam int LUT_W      = 12;
    localparam real FS        = 9600.0;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic txd = 1'b1, v21_sel = 1'b1, orig = 1'b1, tx_en = 1'b1;
    logic [1:0] pattern = 2'b10;
    logic clk16_o, sample_vld_o;
    logic signed [AMP_W-1:0] sample_o;

    int n_cmp = 0, n_bad = 0, max_abs = 0;
    bit done = 0;
    logic bits [40];

    always #2 clk = ~clk;

    fsk_tx_mod #(
        .CLK_HZ(CLK_HZ), .BAUD_DIV(BAUD_DIV), .SAMPLE_DIV(SAMPLE_DIV),
        .PHASE_W(PHASE_W), .AMP_W(AMP_W), .LUT_W(LUT_W)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .txd_i(txd), .v21_sel_i(v21_sel), .orig_i(orig),
        .pattern_i(pattern), .tx_en_i(tx_en), .clk16_o(clk16_o),
        .sample_o(sample_o), .sample_vld_o(sample_vld_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    task automatic get_sample(output int s);
        do @(negedge clk); while (!sample_vld_o);
        s = int'(sample_o);
        if (s > max_abs) max_abs = s;
        if (-s > max_abs) max_abs = -s;
    endtask

    task automatic settle(input int n);
        int s;
        repeat (n) get_sample(s);
    endtask

    task automatic count_cross(input int n, output int c, output int ms);
        int prev, s, d;
        get_sample(prev);
        c = 0; ms = 0;
        repeat (n) begin
            get_sample(s);
            if ((s < 0) != (prev < 0)) c++;
            d = (s > prev) ? s - prev : prev - s;
            if (d > ms) ms = d;
            prev = s;
        end
    endtask

    function automatic int exp_cross(input real f, input int n);
        return $rtoi(2.0 * f * n / FS + 0.5);
    endfunction

    task automatic freq_case(input string req, input logic v21, input logic og,
                             input logic [1:0] pat, input logic d, input real f,
                             input int n, input int tol);
        int c, ms, e;
        v21_sel = v21; orig = og; pattern = pat; txd = d;
        settle(12);
        count_cross(n, c, ms);
        e = exp_cross(f, n);
        check(c >= e - tol && c <= e + tol, req, "sign changes", c, e);
    endtask

    task automatic period_case(input string req, input logic v21, input logic og, input int exp);
        int n;
        v21_sel = v21; orig = og;
        repeat (200) @(negedge clk);
        while (!clk16_o) @(negedge clk);
        n = 0;
        do begin @(negedge clk); n++; end while (!clk16_o);
        check(n == exp, req, "16x strobe period", n, exp);
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog (all requirements): actual hung expected finished");
        finish_run();
    end

    initial begin
        int s, c, ms, e, nz, gap;
        real acc;
        void'($urandom(32'd4242));

        // R12 reset state
        repeat (5) @(negedge clk);
        check(sample_o == 0 && !sample_vld_o && !clk16_o, "R12", "outputs in reset",
              {sample_vld_o, clk16_o, sample_o != 0}, 0);
        rst_n = 1'b1;

        // R11 strobe spacing
        get_sample(s);
        gap = 0;
        do begin @(negedge clk); gap++; end while (!sample_vld_o);
        check(gap == SAMPLE_DIV, "R11", "valid spacing", gap, SAMPLE_DIV);

        // R1 16x clock for each rate
        period_case("R1", 1'b1, 1'b1, 4 * BAUD_DIV);
        period_case("R1", 1'b1, 1'b0, 4 * BAUD_DIV);
        period_case("R1", 1'b0, 1'b1, BAUD_DIV);
        period_case("R1", 1'b0, 1'b0, 16 * BAUD_DIV);

        // R2-R5 tones via forced patterns, txd held opposite (R8)
        freq_case("R2 R8", 1'b1, 1'b1, 2'b10, 1'b0, 980.0,  480, 2);
        freq_case("R2 R8", 1'b1, 1'b1, 2'b11, 1'b1, 1180.0, 480, 2);
        freq_case("R3 R8", 1'b1, 1'b0, 2'b10, 1'b0, 1650.0, 480, 2);
        freq_case("R3 R8", 1'b1, 1'b0, 2'b11, 1'b1, 1850.0, 480, 2);
        freq_case("R4 R8", 1'b0, 1'b1, 2'b10, 1'b0, 1300.0, 480, 2);
        freq_case("R4 R8", 1'b0, 1'b1, 2'b11, 1'b1, 2100.0, 480, 2);
        freq_case("R5 R8", 1'b0, 1'b0, 2'b10, 1'b0, 390.0,  480, 2);
        freq_case("R5 R8", 1'b0, 1'b0, 2'b11, 1'b1, 450.0,  480, 2);

        // R6 data path with constant data
        freq_case("R6", 1'b1, 1'b1, 2'b00, 1'b1, 980.0,  480, 2);
        freq_case("R6", 1'b1, 1'b1, 2'b00, 1'b0, 1180.0, 480, 2);

        // R6 random data on the 1200-baud channel
        v21_sel = 1'b0; orig = 1'b1; pattern = 2'b00;
        settle(12);
        fork
            begin
                for (int b = 0; b < 40; b++) begin
                    bits[b] = 1'($urandom % 2);
                    txd = bits[b];
                    repeat (16 * BAUD_DIV) @(negedge clk);
                end
            end
            count_cross(320, c, ms);
        join
        acc = 0.0;
        for (int b = 0; b < 40; b++)
            acc += 2.0 * (bits[b] ? 1300.0 : 2100.0) * (16.0 * BAUD_DIV / SAMPLE_DIV) / FS;
        e = $rtoi(acc + 0.5);
        check(c >= e - 4 && c <= e + 4, "R6", "random data sign changes", c, e);

        // R7 alternating pattern averages mark and space
        freq_case("R7", 1'b1, 1'b1, 2'b01, 1'b1, 1080.0, 1024, 3);

        // R10 phase continuity across back-channel bit flips
        v21_sel = 1'b0; orig = 1'b0; pattern = 2'b01;
        settle(12);
        count_cross(1000, c, ms);
        e = 2 * ((450 * (1 << LUT_W) + 9599) / 9600) + 4;
        check(ms <= e, "R10", "largest sample step", ms, e);
        e = exp_cross(420.0, 1000);
        check(c >= e - 4 && c <= e + 4, "R7", "back channel alternating", c, e);

        // R9 silence while disabled, then recovery
        tx_en = 1'b0;
        settle(2);
        nz = 0;
        for (int i = 0; i < 40; i++) begin get_sample(s); if (s != 0) nz++; end
        check(nz == 0, "R9", "nonzero samples while disabled", nz, 0);
        tx_en = 1'b1;
        settle(2);
        nz = 0;
        for (int i = 0; i < 40; i++) begin get_sample(s); if (s != 0) nz++; end
        check(nz > 30, "R9", "nonzero samples after re-enable", nz, 40);

        // R13 tight frequency tolerance on the highest tone
        freq_case("R13", 1'b0, 1'b1, 2'b11, 1'b0, 2100.0, 1920, 2);

        // R11 amplitude bound and reach
        check(max_abs <= (1 << (AMP_W - 2)) && max_abs >= (1 << (AMP_W - 2)) - 40,
              "R11", "peak magnitude", max_abs, 1 << (AMP_W - 2));

        finish_run();
    end
endmodule